// File: doc/BRIEF.md
# Bus-Clocked Wiper Step Controller

This block moves the wiper of one of several digitally controlled resistor taps one position at a time, with the step clock and the step direction taken straight from the two serial bus lines. Once the command decoder has accepted a step command and pulses `arm`, the block latches the channel select and enters step mode. Each later SCL high phase is then a step request. SDA held high through the phase asks for a move toward the high terminal, and SDA held low asks for a move toward the low terminal. The move is committed when SCL falls. Step mode ends on a STOP or START event.

SDA must not change while SCL is high during a data bit. A change of SDA in that window means a STOP, a START or a glitch. The block watches SDA for the whole high phase and drops the phase as a step request if SDA moved at any point in it. For every channel the block holds the 6-bit wiper code and decodes it into a 64-line one-hot tap select. Code 0 selects the low end of the array and code 63 selects the high end. While reset is held, each code reloads from its recall field every cycle, so the tap outputs are one-hot at all times.

Top module: `wstep_ctrl`

## Requirements
- R1: A one-cycle `arm` pulse enters step mode and latches `chan_sel` as the active channel. While step mode is off, no SCL or SDA activity changes any code or raises a step pulse.
- R2: In step mode, an SCL high phase with SDA high throughout raises `step_up` for one cycle and adds one to the active channel's code. Both take effect one clock after the first cycle in which SCL is sampled low.
- R3: In step mode, an SCL high phase with SDA low throughout raises `step_dn` for one cycle and subtracts one from the active channel's code, with the same timing as R2.
- R4: Codes saturate. A step up at 63 and a step down at 0 leave the code unchanged, and the matching step pulse is still raised.
- R5: If SDA changes at any sampled cycle of an SCL high phase, that phase produces no step.
- R6: A `stop_evt` or `start_evt` pulse ends step mode when `arm` is low in the same cycle. If the event falls in the same cycle as the SCL fall, that phase produces no step.
- R7: Only a high phase whose SCL rise is sampled while step mode is already on can produce a step. A phase that is in progress when `arm` arrives is ignored.
- R8: For channel c, bit c*64+k of `taps` is high exactly when that channel's code equals k. Exactly one bit of each 64-bit field is high.
- R9: While `rst_n` is low, each channel's code loads from `recall_codes[c*6 +: 6]` on every clock, and both step pulses are low.
- R10: A step changes only the active channel's code. `step_up` and `step_dn` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, used for recall |
| scl | input | 1 | Serial clock line, already synchronized to clk |
| sda | input | 1 | Serial data line, already synchronized to clk |
| arm | input | 1 | One-cycle pulse from the command decoder: step command accepted |
| chan_sel | input | 2 | Channel to step, sampled with `arm` |
| stop_evt | input | 1 | One-cycle STOP detection pulse |
| start_evt | input | 1 | One-cycle START detection pulse |
| recall_codes | input | 24 | Saved wiper codes loaded during reset, 6 bits per channel |
| step_up | output | 1 | One-cycle pulse per committed upward step |
| step_dn | output | 1 | One-cycle pulse per committed downward step |
| taps | output | 256 | One-hot tap selects, 64 bits per channel |

## Verification
Two things can coincide in one cycle: the commit of a step at the SCL fall, and a bus event that ends step mode. The bench forces this by lowering SCL and pulsing `stop_evt` in the same clock. It then confirms that no pulse was counted, that the codes are unchanged, and that later clean phases do nothing (R6). A second overlap is an `arm` pulse that arrives inside an SCL high phase. The bench judges this by counting pulses at the ports, expecting none for that phase and exactly one for the next clean phase (R7).

// File: rtl/wstep_pkg.sv
package wstep_pkg;

  // Per-channel move request for one clock
  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_UP   = 2'd1,
    MOVE_DOWN = 2'd2
  } move_e;

  // Verdict of one SCL high phase
  typedef struct packed {
    logic commit;       // phase qualifies as a step
    logic toward_high;  // SDA level held during the phase
  } phase_verdict_t;

endpackage

// File: rtl/wstep_phase.sv
// Qualifies each SCL high phase as a clean step request.
module wstep_phase
  import wstep_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl,
  input  logic           sda,
  input  logic           mode_on,
  input  logic           abort,
  output logic           scl_rise,
  output logic           scl_fall,
  output phase_verdict_t verdict
);

  logic scl_q;
  logic window;     // phase opened while step mode was on
  logic held_sda;   // SDA level sampled at the rise
  logic disturbed;  // SDA moved, or an event arrived, during the phase

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      window    <= 1'b0;
      held_sda  <= 1'b0;
      disturbed <= 1'b0;
    end else begin
      scl_q <= scl;
      if (scl_rise) begin
        window    <= mode_on & ~abort;
        held_sda  <= sda;
        disturbed <= 1'b0;
      end else if (scl & scl_q) begin
        if ((sda != held_sda) || abort) disturbed <= 1'b1;
      end else if (scl_fall) begin
        window <= 1'b0;
      end
    end
  end

  always_comb begin
    verdict.commit      = scl_fall & window & ~disturbed & ~abort & mode_on;
    verdict.toward_high = held_sda;
  end

endmodule

// File: rtl/wstep_mode.sv
// Step-mode flag and latched channel.
module wstep_mode #(
  parameter int unsigned CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic [CH_W-1:0] chan_sel,
  input  logic            stop_evt,
  input  logic            start_evt,
  output logic            mode_on,
  output logic [CH_W-1:0] mode_chan
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_on   <= 1'b0;
      mode_chan <= '0;
    end else if (arm) begin
      mode_on   <= 1'b1;
      mode_chan <= chan_sel;
    end else if (stop_evt || start_evt) begin
      mode_on <= 1'b0;
    end
  end

endmodule

// File: rtl/wstep_wiper.sv
// One channel: saturating wiper code and its one-hot tap decode.
module wstep_wiper
  import wstep_pkg::*;
#(
  parameter int unsigned CODE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CODE_W-1:0]        recall,
  input  move_e                    move,
  output logic [CODE_W-1:0]        code,
  output logic [(1<<CODE_W)-1:0]   tap
);

  localparam int unsigned NTAP = 1 << CODE_W;
  localparam logic [CODE_W-1:0] TOP = '1;

  function automatic logic [CODE_W-1:0] next_code(input logic [CODE_W-1:0] c,
                                                  input move_e m);
    case (m)
      MOVE_UP:   return (c == TOP) ? c : c + 1'b1;
      MOVE_DOWN: return (c == '0)  ? c : c - 1'b1;
      default:   return c;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) code <= recall;
    else        code <= next_code(code, move);
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    assign tap[k] = (code == CODE_W'(k));
  end

endmodule

// File: rtl/wstep_ctrl.sv
// Top: bus-clocked wiper stepping for NCH channels.
module wstep_ctrl
  import wstep_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CODE_W = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            scl,
  input  logic                            sda,
  input  logic                            arm,
  input  logic [((NCH>1)?$clog2(NCH):1)-1:0] chan_sel,
  input  logic                            stop_evt,
  input  logic                            start_evt,
  input  logic [NCH*CODE_W-1:0]           recall_codes,
  output logic                            step_up,
  output logic                            step_dn,
  output logic [NCH*(1<<CODE_W)-1:0]      taps
);

  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned NTAP = 1 << CODE_W;

  // Named internal events, visible to the bound checker
  logic            mode_on;
  logic [CH_W-1:0] mode_chan;
  logic            scl_rise;
  logic            scl_fall;
  logic            bus_abort;
  phase_verdict_t  verdict;

  assign bus_abort = stop_evt | start_evt;

  wstep_mode #(.CH_W(CH_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .chan_sel  (chan_sel),
    .stop_evt  (stop_evt),
    .start_evt (start_evt),
    .mode_on   (mode_on),
    .mode_chan (mode_chan)
  );

  wstep_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl),
    .sda      (sda),
    .mode_on  (mode_on),
    .abort    (bus_abort),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .verdict  (verdict)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    move_e             mv;
    logic [CODE_W-1:0] code;
    assign mv = (verdict.commit && (mode_chan == CH_W'(c)))
                  ? (verdict.toward_high ? MOVE_UP : MOVE_DOWN)
                  : MOVE_NONE;
    wstep_wiper #(.CODE_W(CODE_W)) u_wiper (
      .clk    (clk),
      .rst_n  (rst_n),
      .recall (recall_codes[c*CODE_W +: CODE_W]),
      .move   (mv),
      .code   (code),
      .tap    (taps[c*NTAP +: NTAP])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_up <= 1'b0;
      step_dn <= 1'b0;
    end else begin
      step_up <= verdict.commit &  verdict.toward_high;
      step_dn <= verdict.commit & ~verdict.toward_high;
    end
  end

endmodule

// File: rtl/wstep_ctrl_chk.sv
module wstep_ctrl_chk #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CODE_W = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         scl,
  input logic                         arm,
  input logic                         stop_evt,
  input logic                         start_evt,
  input logic                         step_up,
  input logic                         step_dn,
  input logic                         mode_on,
  input logic [((NCH>1)?$clog2(NCH):1)-1:0] mode_chan,
  input logic [NCH*(1<<CODE_W)-1:0]   taps
);

  localparam int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned NTAP = 1 << CODE_W;

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  p_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> $past(mode_on));

  p_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> mode_on);

  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop_evt || start_evt) && !arm) |=> !mode_on);

  p_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> ($past(!scl) && $past(scl, 2)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(taps[c*NTAP +: NTAP]));

    p_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && $past(mode_chan) == CH_W'(c) && !$past(taps[c*NTAP + NTAP - 1]))
        |-> taps[c*NTAP +: NTAP] == ($past(taps[c*NTAP +: NTAP]) << 1));

    p_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_dn && $past(mode_chan) == CH_W'(c) && !$past(taps[c*NTAP]))
        |-> taps[c*NTAP +: NTAP] == ($past(taps[c*NTAP +: NTAP]) >> 1));

    p_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((step_up && $past(taps[c*NTAP + NTAP - 1])) ||
       (step_dn && $past(taps[c*NTAP]))) && $past(mode_chan) == CH_W'(c)
        |-> $stable(taps[c*NTAP +: NTAP]));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !((step_up || step_dn) && $past(mode_chan) == CH_W'(c)))
        |-> $stable(taps[c*NTAP +: NTAP]));
  end

endmodule

bind wstep_ctrl wstep_ctrl_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl       (scl),
  .arm       (arm),
  .stop_evt  (stop_evt),
  .start_evt (start_evt),
  .step_up   (step_up),
  .step_dn   (step_dn),
  .mode_on   (mode_on),
  .mode_chan (mode_chan),
  .taps      (taps)
);

// File: tb/wstep_ctrl_test.sv
`timescale 1ns/1ps
module wstep_ctrl_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scl = 1'b1;
  logic         sda = 1'b1;
  logic         arm = 1'b0;
  logic [1:0]   chan_sel = 2'd0;
  logic         stop_evt = 1'b0;
  logic         start_evt = 1'b0;
  logic [23:0]  recall_codes;
  logic         step_up;
  logic         step_dn;
  logic [255:0] taps;

  int checks = 0;
  int failures = 0;
  int n_up = 0, n_dn = 0, n_both = 0;
  int e_up = 0, e_dn = 0;
  int exp_code [4];
  bit exp_on = 0;
  int exp_ch = 0;

  always #4 clk = ~clk;  // 125 MHz

  wstep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .arm(arm),
    .chan_sel(chan_sel), .stop_evt(stop_evt), .start_evt(start_evt),
    .recall_codes(recall_codes), .step_up(step_up), .step_dn(step_dn),
    .taps(taps)
  );

  always @(negedge clk) if (rst_n) begin
    if (step_up) n_up++;
    if (step_dn) n_dn++;
    if (step_up && step_dn) n_both++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int sat(input int c, input bit up);
    if (up) return (c >= 63) ? 63 : c + 1;
    return (c <= 0) ? 0 : c - 1;
  endfunction

  task automatic check_int(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic check_taps(input string req);
    for (int c = 0; c < 4; c++) begin
      logic [63:0] want;
      want = 64'd1 << exp_code[c];
      checks++;
      if (taps[c*64 +: 64] !== want) begin
        failures++;
        $display("FAIL %s taps ch%0d: actual=%h expected=%h", req, c, taps[c*64 +: 64], want);
      end
    end
    check_int(req, "up pulses", n_up, e_up);
    check_int(req, "down pulses", n_dn, e_dn);
  endtask

  task automatic do_arm(input int c);
    chan_sel = 2'(c); arm = 1'b1; tick(1); arm = 1'b0;
    exp_on = 1; exp_ch = c;
  endtask

  task automatic phase(input bit up);
    scl = 1'b0; tick(2); sda = up; tick(2);
    scl = 1'b1; tick(4); scl = 1'b0; tick(3);
    if (exp_on) begin
      exp_code[exp_ch] = sat(exp_code[exp_ch], up);
      if (up) e_up++; else e_dn++;
    end
  endtask

  task automatic glitch_phase(input bit first);
    scl = 1'b0; tick(2); sda = first; tick(2);
    scl = 1'b1; tick(2); sda = ~first; tick(2); scl = 1'b0; tick(3);
  endtask

  task automatic stop_seq();
    scl = 1'b0; tick(2); sda = 1'b0; tick(2);
    scl = 1'b1; tick(2); sda = 1'b1; stop_evt = 1'b1; tick(1);
    stop_evt = 1'b0; tick(3);
    exp_on = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    exp_code[0] = 5; exp_code[1] = 20; exp_code[2] = 0; exp_code[3] = 63;
    recall_codes = {6'd63, 6'd0, 6'd20, 6'd5};
    tick(4);
    check_taps("R9");                       // recall during reset, R8 one-hot
    check_int("R9", "step_up in reset", int'(step_up), 0);
    rst_n = 1'b1; tick(2);
    check_taps("R8");

    phase(1); phase(0);                     // R1: no mode, no effect
    check_taps("R1");

    do_arm(1); phase(1); phase(1); phase(1); // R2
    check_taps("R2");
    phase(0);                               // R3
    check_taps("R3");

    do_arm(2); phase(0); phase(0);          // R4 low end
    do_arm(3); phase(1);                    // R4 high end
    check_taps("R4");

    do_arm(0); glitch_phase(1); glitch_phase(0); // R5
    check_taps("R5");

    stop_seq(); phase(1); phase(0);         // R6 stop ends mode
    check_taps("R6");

    do_arm(0);                              // R6 event coincident with fall
    scl = 1'b0; tick(2); sda = 1'b1; tick(2); scl = 1'b1; tick(4);
    scl = 1'b0; stop_evt = 1'b1; tick(1); stop_evt = 1'b0; tick(3);
    exp_on = 0; phase(1);
    check_taps("R6");

    do_arm(1); start_evt = 1'b1; tick(1); start_evt = 1'b0; exp_on = 0;
    phase(0);                               // R6 start ends mode
    check_taps("R6");

    scl = 1'b0; tick(2); sda = 1'b1; tick(2); scl = 1'b1; tick(2);
    do_arm(0); tick(2); scl = 1'b0; tick(3); // R7 phase already open
    check_taps("R7");
    phase(1);
    check_taps("R7");

    for (int it = 0; it < 200; it++) begin
      int n;
      stop_seq();
      do_arm(int'($urandom_range(0, 3)));
      n = int'($urandom_range(1, 14));
      for (int k = 0; k < n; k++) begin
        int r;
        r = int'($urandom_range(0, 9));
        if (r == 0) glitch_phase(1'($urandom_range(0, 1)));
        else        phase(1'(r % 2));
      end
      if ($urandom_range(0, 1) == 1) stop_seq();
      else begin start_evt = 1'b1; tick(1); start_evt = 1'b0; exp_on = 0; end
      check_taps("R10");
    end
    check_int("R10", "both pulses", n_both, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule